// File: doc/BRIEF.md
# Two-Wire Register Access Target

This block lets a host reach a 128-entry bank of 8-bit registers over a two-wire serial bus (SCL clock, SDA data). It runs entirely on the system clock. Both bus lines are passed through a synchronizer. Bus events are found as level changes of the synchronized lines, so SCL is never used as a clock. The target's 7-bit bus address has a fixed upper part, 01011. Its two low bits come from strap inputs, so up to four targets can share one bus.

A write transaction carries the address byte, then a pointer byte, then any number of data bytes. Each data byte goes to the register the pointer selects, and the pointer then steps on by one. A read transaction returns bytes starting at the current pointer and continues for as long as the host acknowledges. The pointer is kept between transactions. A host can therefore set it in a write, issue a repeated START, and read from that point. Register 0 is treated as a port, not a location: the pointer does not move off it. This lets a host move a block of bytes through that one entry.

The bank side is a one-way write stream and a read request. `reg_wr_valid` has no ready signal. The bus cannot be held, because the target does not stretch the clock, so the bank must accept every write beat in the cycle it is offered. A read is requested with `reg_rd_req`, and the bank returns `reg_rd_data` in the following clock cycle.

Top module: `i2c_regbank_slave`

## Requirements
- R1: While reset is asserted and after it is released, SDA is released (`sda_oe` = 0) and neither `reg_wr_valid` nor `reg_rd_req` is raised until a transaction calls for it.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START or repeated START in any state begins a new address byte, and a STOP returns the block to idle.
- R3: The first byte after a START is taken MSB first as seven address bits followed by a direction bit. Byte bits 7..3 must be 01011 and byte bits 2..1 must equal `strap_i[1:0]`. Bit 0 = 1 means read and 0 means write. On a match the target pulls SDA low during the ninth SCL pulse.
- R4: On an address mismatch the target leaves SDA released for the ninth pulse and for every later bit. It raises no write or read strobe until the next START or STOP.
- R5: In a write, the byte after the address is acknowledged and loads the pointer from its bits 6..0. Bit 7 is ignored.
- R6: Each further write byte is acknowledged. After its eighth bit it is offered as a single-cycle `reg_wr_valid` beat, with `reg_addr` equal to the pointer and `reg_wr_data` equal to the byte.
- R7: After each data byte, read or written, the pointer steps by one, wrapping from 127 to 0. A pointer of 0 does not step.
- R8: In a read, the target sends the register at the pointer MSB first, changing SDA only while SCL is low. If the host acknowledges (SDA low on the ninth pulse), the next register follows. If the host does not acknowledge, SDA stays released until the next START or STOP.
- R9: The pointer keeps its value across STOP and START, so a read without a pointer byte continues from where the last transaction left off.
- R10: SDA is only ever pulled low or released. `sda_oe` = 1 means pull low, and it changes only while SCL is low, except on the cycle after a START or STOP.
- R11: A STOP or START that arrives before the eighth bit of a data byte discards the partial byte: no write beat is offered and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples both bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_i | input | 2 | Low two bits of the bus address |
| reg_addr | output | 7 | Register pointer, valid with either strobe |
| reg_wr_valid | output | 1 | Single-cycle write beat, no back-pressure |
| reg_wr_data | output | 8 | Byte to write, valid with `reg_wr_valid` |
| reg_rd_req | output | 1 | Single-cycle read request for `reg_addr` |
| reg_rd_data | input | 8 | Read data, valid one cycle after `reg_rd_req` |

## Verification
Write bursts are started at ordinary pointers, at the top of the range and at register 0. These separate a stepping pointer, the wrap to 0 and the hold at 0. Reads are tried in two ways: with a pointer byte and a repeated START, and bare after a STOP. This separates a pointer that is kept across transactions from one that is reset, and an acknowledged continuation from a NACK that ends the read. Addresses that differ from the expected one only in the fixed prefix or only in the strap bits show whether the target stays silent on every later bit. A data byte cut short by a STOP shows that half-received bytes are dropped.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK,
    ST_SKIP
  } phase_e;

  function automatic logic is_rx_phase(phase_e p);
    return (p == ST_ADDR) || (p == ST_REG) || (p == ST_WDATA);
  endfunction

  function automatic logic is_ack_phase(phase_e p);
    return (p == ST_ADDR_ACK) || (p == ST_REG_ACK) || (p == ST_WDATA_ACK);
  endfunction

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  // Bus lines idle high, so the chain resets to 1.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= 1'b1;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/i2c_rb_cond.sv
module i2c_rb_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // SDA edges only count as bus conditions while SCL stays high across them.
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_rb_ptr.sv
module i2c_rb_ptr #(
  parameter int AW        = 7,
  parameter bit HOLD_ZERO = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  output logic [AW-1:0] ptr
);

  logic step_ok;

  generate
    if (HOLD_ZERO) begin : g_hold
      assign step_ok = (ptr != '0);
    end else begin : g_free
      assign step_ok = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ptr <= '0;
    else if (load)            ptr <= load_val;
    else if (adv && step_ok)  ptr <= ptr + 1'b1;
  end

endmodule

// File: rtl/i2c_rb_fsm.sv
module i2c_rb_fsm
  import i2c_rb_pkg::*;
#(
  parameter int AW      = 7,
  parameter int DW      = 8,
  parameter int STRAP_W = 2,
  parameter int PFX_W   = 5,
  parameter logic [PFX_W-1:0] PREFIX = 5'b01011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic               sda_s,
  input  logic [STRAP_W-1:0] strap,
  input  logic [DW-1:0]      rd_data,
  output logic               ptr_load,
  output logic [AW-1:0]      ptr_val,
  output logic               ptr_adv,
  output logic               wr_valid,
  output logic [DW-1:0]      wr_data,
  output logic               rd_req,
  output logic               sda_oe
);

  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW);

  phase_e        state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sr;
  logic [DW-1:0] tx;
  logic          rw;
  logic          host_ack;
  logic          rd_wait;
  logic          addr_hit;

  assign addr_hit = (sr[DW-1 -: AW] == {PREFIX, strap});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sr       <= '0;
      tx       <= '0;
      rw       <= 1'b0;
      host_ack <= 1'b0;
      rd_wait  <= 1'b0;
      ptr_load <= 1'b0;
      ptr_val  <= '0;
      ptr_adv  <= 1'b0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
      rd_req   <= 1'b0;
    end else begin
      ptr_load <= 1'b0;
      ptr_adv  <= 1'b0;
      wr_valid <= 1'b0;
      rd_req   <= 1'b0;
      rd_wait  <= rd_req;
      if (rd_wait) tx <= rd_data;

      if (start_det) begin
        state <= ST_ADDR;
        cnt   <= '0;
      end else if (stop_det) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        unique case (state)
          ST_ADDR, ST_REG, ST_WDATA: begin
            if (scl_rise) begin
              sr  <= {sr[DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST_BIT) begin
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  state  <= ST_ADDR_ACK;
                  rw     <= sr[0];
                  rd_req <= sr[0];
                end else begin
                  state <= ST_SKIP;
                end
              end else if (state == ST_REG) begin
                ptr_load <= 1'b1;
                ptr_val  <= sr[AW-1:0];
                state    <= ST_REG_ACK;
              end else begin
                wr_valid <= 1'b1;
                wr_data  <= sr;
                ptr_adv  <= 1'b1;
                state    <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt   <= '0;
              state <= rw ? ST_RDATA : ST_REG;
            end
          end
          ST_REG_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              cnt   <= '0;
              state <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == LAST_BIT) begin
                state   <= ST_RDATA_ACK;
                ptr_adv <= 1'b1;
              end else begin
                tx <= {tx[DW-2:0], 1'b0};
              end
            end
          end
          ST_RDATA_ACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_s;
              rd_req   <= ~sda_s;
            end else if (scl_fall) begin
              cnt   <= '0;
              state <= host_ack ? ST_RDATA : ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe = is_ack_phase(state) || ((state == ST_RDATA) && !tx[DW-1]);

  // R2
  addr_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR && cnt == '0));

  // R4
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> (!wr_valid && !rd_req && !sda_oe));

  // R3
  ack_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR_ACK) |-> (sr[DW-1 -: AW] == {PREFIX, strap}));

  // R11
  rx_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_rx_phase(state) |-> (cnt <= LAST_BIT));

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter int AW          = 7,
  parameter int DW          = 8,
  parameter int STRAP_W     = 2,
  parameter int SYNC_STAGES = 2,
  parameter bit HOLD_ZERO   = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [AW-1:0]      reg_addr,
  output logic               reg_wr_valid,
  output logic [DW-1:0]      reg_wr_data,
  output logic               reg_rd_req,
  input  logic [DW-1:0]      reg_rd_data
);

  localparam int PFX_W = AW - STRAP_W;
  localparam logic [PFX_W-1:0] PREFIX = PFX_W'(5'b01011);
  localparam int NLINES = 2;

  logic [NLINES-1:0] line_raw;
  logic [NLINES-1:0] line_s;
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic ptr_load, ptr_adv;
  logic [AW-1:0] ptr_val;

  assign line_raw = {sda_i, scl_i};

  generate
    for (genvar l = 0; l < NLINES; l++) begin : g_line
      i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (line_raw[l]),
        .dout (line_s[l])
      );
    end
  endgenerate

  assign scl_s = line_s[0];
  assign sda_s = line_s[1];

  i2c_rb_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_rb_fsm #(
    .AW(AW), .DW(DW), .STRAP_W(STRAP_W), .PFX_W(PFX_W), .PREFIX(PREFIX)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_s    (sda_s),
    .strap    (strap_i),
    .rd_data  (reg_rd_data),
    .ptr_load (ptr_load),
    .ptr_val  (ptr_val),
    .ptr_adv  (ptr_adv),
    .wr_valid (reg_wr_valid),
    .wr_data  (reg_wr_data),
    .rd_req   (reg_rd_req),
    .sda_oe   (sda_oe)
  );

  i2c_rb_ptr #(.AW(AW), .HOLD_ZERO(HOLD_ZERO)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ptr_load),
    .load_val(ptr_val),
    .adv     (ptr_adv),
    .ptr     (reg_addr)
  );

  logic [AW-1:0] addr_plus1;
  assign addr_plus1 = reg_addr + 1'b1;

  // R7
  ptr_step_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr_valid) |->
      (reg_addr == ((HOLD_ZERO && $past(reg_addr) == '0) ? '0 : $past(addr_plus1))));

  // R6
  wr_single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_valid |=> !reg_wr_valid);

  // R10
  sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

  // R1
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_valid && reg_rd_req));

endmodule

// File: tb/tb_i2c_regbank_slave.sv
module tb_i2c_regbank_slave;

  localparam int Q = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       scl_m, sda_m;
  logic [1:0] strap;
  logic       sda_oe;
  logic [6:0] reg_addr;
  logic       reg_wr_valid, reg_rd_req;
  logic [7:0] reg_wr_data, reg_rd_data;
  wire        sda_bus = sda_m & ~sda_oe;

  i2c_regbank_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_i(strap), .reg_addr(reg_addr), .reg_wr_valid(reg_wr_valid),
    .reg_wr_data(reg_wr_data), .reg_rd_req(reg_rd_req), .reg_rd_data(reg_rd_data)
  );

  // Behavioural bank attached to the block
  logic [7:0] bank [128];
  always @(posedge clk) begin
    if (reg_rd_req)   reg_rd_data <= bank[reg_addr];
    if (reg_wr_valid) bank[reg_addr] <= reg_wr_data;
  end

  // Reference model state
  int   ref_mem [128];
  int   mptr;
  int   exp_wa[$];
  int   exp_wd[$];
  int   vectors = 0;
  int   errors  = 0;
  logic chk_oe  = 1'b0;
  logic exp_oe  = 1'b0;
  string cur_req = "R1";

  task automatic fail(input string req, input string what, input int act, input int expv);
    errors++;
    $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      if (chk_oe) begin
        vectors++;
        if (sda_oe !== exp_oe) fail(cur_req, "sda_oe", int'(sda_oe), int'(exp_oe));
      end
      if (reg_wr_valid) begin
        vectors++;
        if (exp_wa.size() == 0) begin
          fail("R6", "unexpected write beat addr", int'(reg_addr), -1);
        end else begin
          int a, d;
          a = exp_wa.pop_front();
          d = exp_wd.pop_front();
          if (int'(reg_addr) != a) fail("R7", "write address", int'(reg_addr), a);
          if (int'(reg_wr_data) != d) fail("R6", "write data", int'(reg_wr_data), d);
        end
      end
    end
  end

  function automatic int step(input int p);
    return (p == 0) ? 0 : ((p + 1) % 128);
  endfunction

  task automatic qw();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic clk_bit(input logic b, input logic eoe, output logic got);
    sda_m = b; qw();
    scl_m = 1'b1; exp_oe = eoe; chk_oe = 1'b1;
    qw(); got = sda_bus; qw();
    chk_oe = 1'b0; scl_m = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, input logic eack, input int nbits);
    logic g;
    for (int i = 7; i >= 8 - nbits; i--) clk_bit(b[i], 1'b0, g);
    if (nbits == 8) begin
      clk_bit(1'b1, eack, g);
      vectors++;
      if (g !== ~eack) fail(cur_req, "ack level on SDA", int'(g), int'(~eack));
    end
  endtask

  task automatic recv_byte(input logic [7:0] ed, input logic mack);
    logic g;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, ~ed[i], g);
      vectors++;
      if (g !== ed[i]) fail("R8", "read bit", int'(g), int'(ed[i]));
    end
    clk_bit(~mack, 1'b0, g);
    sda_m = 1'b1;
  endtask

  logic [7:0] payload[$];

  task automatic wr_txn(input logic [6:0] dev, input logic [7:0] regb, input logic hit);
    bus_start();
    cur_req = hit ? "R3" : "R4";
    send_byte({dev, 1'b0}, hit, 8);
    cur_req = hit ? "R5" : "R4";
    if (hit) mptr = int'(regb[6:0]);
    send_byte(regb, hit, 8);
    foreach (payload[k]) begin
      cur_req = hit ? "R6" : "R4";
      if (hit) begin
        exp_wa.push_back(mptr); exp_wd.push_back(int'(payload[k]));
        ref_mem[mptr] = int'(payload[k]);
        mptr = step(mptr);
      end
      send_byte(payload[k], hit, 8);
    end
    bus_stop();
  endtask

  task automatic rd_txn(input logic [6:0] dev, input int n, input logic setp, input logic [7:0] regb);
    bus_start();
    if (setp) begin
      cur_req = "R5";
      send_byte({dev, 1'b0}, 1'b1, 8);
      mptr = int'(regb[6:0]);
      send_byte(regb, 1'b1, 8);
      cur_req = "R2";
      bus_rstart();
    end
    cur_req = "R3";
    send_byte({dev, 1'b1}, 1'b1, 8);
    cur_req = "R8";
    for (int k = 0; k < n; k++) begin
      recv_byte(ref_mem[mptr][7:0], k < n - 1);
      mptr = step(mptr);
    end
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [6:0] dev;
    for (int i = 0; i < 128; i++) begin
      bank[i] = 8'((i * 37 + 11) & 8'hFF);
      ref_mem[i] = (i * 37 + 11) & 8'hFF;
    end
    mptr = 0;
    scl_m = 1'b1; sda_m = 1'b1; strap = 2'b01; rst_n = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    // R1: outputs quiet in and after reset
    vectors++; if (sda_oe !== 1'b0) fail("R1", "sda_oe in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    vectors++; if (sda_oe !== 1'b0) fail("R1", "sda_oe after reset", int'(sda_oe), 0);
    vectors++; if (reg_wr_valid || reg_rd_req) fail("R1", "strobe after reset", 1, 0);

    dev = {5'b01011, strap};
    // R5/R6/R7: burst write at ordinary pointer
    payload = '{8'hA5, 8'h3C, 8'h5A};
    wr_txn(dev, 8'h10, 1'b1);
    // R8/R2: pointer byte, repeated START, read back with ACK chain then NACK
    rd_txn(dev, 3, 1'b1, 8'h10);
    // R9: bare read continues from the kept pointer (0x13)
    rd_txn(dev, 2, 1'b0, 8'h00);
    // R4: prefix mismatch then strap mismatch
    payload = '{8'hFF, 8'h00};
    wr_txn({5'b01010, strap}, 8'h20, 1'b0);
    wr_txn({5'b01011, ~strap}, 8'h21, 1'b0);
    // R7: hold at register 0
    payload = '{8'h11, 8'h22};
    wr_txn(dev, 8'h00, 1'b1);
    rd_txn(dev, 2, 1'b1, 8'h00);
    // R7: wrap from 127 to 0
    payload = '{8'h71, 8'h72, 8'h73};
    wr_txn(dev, 8'h7E, 1'b1);
    rd_txn(dev, 2, 1'b1, 8'h7F);
    // R5: bit 7 of the pointer byte ignored (0x85 -> 0x05)
    payload = '{8'hC3};
    wr_txn(dev, 8'h85, 1'b1);
    rd_txn(dev, 1, 1'b1, 8'h05);
    // R11: STOP inside a data byte drops it
    bus_start();
    cur_req = "R3"; send_byte({dev, 1'b0}, 1'b1, 8);
    cur_req = "R5"; mptr = 8'h30; send_byte(8'h30, 1'b1, 8);
    cur_req = "R11"; send_byte(8'hEE, 1'b0, 4);
    bus_stop();
    rd_txn(dev, 1, 1'b0, 8'h00);
    // R3: new strap value selects a new address
    strap = 2'b10;
    dev = {5'b01011, strap};
    payload = '{8'h9D};
    wr_txn(dev, 8'h44, 1'b1);
    rd_txn(dev, 1, 1'b1, 8'h44);

    repeat (20) @(posedge clk);
    #1;
    vectors++;
    if (exp_wa.size() != 0) fail("R6", "missing write beats", 0, exp_wa.size());
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule